// File: doc/BRIEF.md
# Cache-Line Burst Beat Sequencer

This block turns a cache-line burst request into the sequence of double-word beats a 64-bit data bus needs to move one 32-byte line. A request carries the line address, a read/write direction and a flag saying whether the write answers a snoop (an intervention). Once the request is accepted, the block presents one beat at a time: the index of the double word within the line and the full beat address. It moves to the next beat on each data acknowledge and signals which beat is the last one.

Two orderings are produced. Reads and intervention writes begin at the double word the request addresses and step upward, wrapping from the top of the line back to double word zero. Ordinary burst writes ignore the addressed double word and always run 0, 1, 2, 3. A request whose byte offset within the double word is not zero is refused with a one-cycle error pulse.

Bus arbitration, snooping, the data path and the cache arrays belong to neighbouring blocks.

Top module: `burst_beat_seq`

## Requirements
- R1: After reset, and in any cycle while reset is held, `beat_valid`, `beat_last`, `req_accept` and `req_error` are all 0.
- R2: For a read, the first beat index equals address bits [4:3] (the critical double word), and each acknowledged beat adds 1 modulo 4, so a start of 2 gives 2,3,0,1.
- R3: An intervention write (`req_write`=1, `req_intervene`=1) uses the same critical-first, wrapping order as a read.
- R4: An ordinary write (`req_write`=1, `req_intervene`=0) always gives the order 0,1,2,3, whatever address bits [4:3] hold.
- R5: While a beat is valid, `beat_addr` carries bits [31:5] of the request address, the current beat index in bits [4:3], and zeros in bits [2:0].
- R6: The beat index and beat address change only at a clock edge where `beat_valid` and `data_ack` are both 1; an acknowledge while idle has no effect.
- R7: `beat_last` is 1 exactly while the fourth beat is presented; after that beat is acknowledged, `beat_valid` is 0 in the following cycle.
- R8: A request seen while idle with address bits [2:0] not zero produces `req_error`=1 for exactly one cycle, no `req_accept` and no beats.
- R9: A request is taken only when idle; a request presented during a burst, well-formed or not, causes no accept, no error and no change to the running sequence.
- R10: A request taken while idle raises `req_accept` for one cycle, the cycle after it is sampled, in the same cycle the first beat becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request present |
| req_addr | input | 32 | Request address, bit 0 least significant |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_intervene | input | 1 | Write is an intervention (critical-first order) |
| data_ack | input | 1 | Current beat is transferred |
| req_accept | output | 1 | One-cycle pulse: request taken, first beat valid |
| req_error | output | 1 | One-cycle pulse: request refused for non-zero byte offset |
| beat_valid | output | 1 | A beat is being presented |
| beat_idx | output | 2 | Double-word index of the current beat |
| beat_addr | output | 32 | Byte address of the current beat |
| beat_last | output | 1 | Current beat is the fourth of the burst |

## Verification
The assertions assume the request fields are stable in the cycle `req_valid` is sampled and that `data_ack` is only meaningful while a beat is valid; they check the order rules against the sampled request one cycle later. The bench drives every input at the falling edge, holds `req_valid` for a single cycle per request, and deliberately raises `data_ack` while idle and `req_valid` mid-burst so the ignore rules are exercised rather than avoided. Stalls are inserted by dropping `data_ack` on chosen beats while keeping all other inputs legal.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_BURST = 1'b1
  } seq_state_t;

  // Order selected for a burst
  typedef enum logic {
    ORD_CRITICAL = 1'b0,
    ORD_ZERO     = 1'b1
  } seq_order_t;

endpackage

// File: rtl/burst_start_sel.sv
module burst_start_sel #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFS_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic              intervene,
  output logic [IDX_W-1:0]  start_idx,
  output logic              ofs_bad
);
  import burst_seq_pkg::*;

  seq_order_t order;

  always_comb begin
    order     = (is_write && !intervene) ? ORD_ZERO : ORD_CRITICAL;
    start_idx = (order == ORD_ZERO) ? '0 : addr[OFS_W+IDX_W-1:OFS_W];
    ofs_bad   = |addr[OFS_W-1:0];
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEATS = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      idx <= '0;
    end else if (load) begin
      cnt <= '0;
      idx <= start_idx;
    end else if (adv && !last) begin
      cnt <= cnt + 1'b1;
      idx <= idx + 1'b1;
    end
  end

  assign last = (cnt == IDX_W'(BEATS - 1));

  // R2
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !last && !load) |=> (idx == $past(idx) + 1'b1));

  // R6
  hold_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load) |=> ($stable(idx) && $stable(cnt)));

endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        req_valid,
  input  logic [ADDR_W-1:0]                           req_addr,
  input  logic                                        req_write,
  input  logic                                        req_intervene,
  input  logic                                        data_ack,
  output logic                                        req_accept,
  output logic                                        req_error,
  output logic                                        beat_valid,
  output logic [$clog2(LINE_BYTES/BEAT_BYTES)-1:0]    beat_idx,
  output logic [ADDR_W-1:0]                           beat_addr,
  output logic                                        beat_last
);
  import burst_seq_pkg::*;

  localparam int BEATS    = LINE_BYTES / BEAT_BYTES;
  localparam int IDX_W    = $clog2(BEATS);
  localparam int OFS_W    = $clog2(BEAT_BYTES);
  localparam int LINE_LSB = OFS_W + IDX_W;

  seq_state_t                 state;
  logic [ADDR_W-1:LINE_LSB]   line_q;
  logic [IDX_W-1:0]           start_idx;
  logic [IDX_W-1:0]           cur_idx;
  logic                       ofs_bad;
  logic                       cnt_last;
  logic                       take;
  logic                       take_ok;
  logic                       adv;

  burst_start_sel #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFS_W  (OFS_W)
  ) u_start (
    .addr      (req_addr),
    .is_write  (req_write),
    .intervene (req_intervene),
    .start_idx (start_idx),
    .ofs_bad   (ofs_bad)
  );

  assign take    = req_valid && (state == SEQ_IDLE);
  assign take_ok = take && !ofs_bad;
  assign adv     = beat_valid && data_ack;

  burst_beat_ctr #(
    .BEATS (BEATS),
    .IDX_W (IDX_W)
  ) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (take_ok),
    .start_idx (start_idx),
    .adv       (adv),
    .idx       (cur_idx),
    .last      (cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      req_accept <= 1'b0;
      req_error  <= 1'b0;
      line_q     <= '0;
    end else begin
      req_accept <= take_ok;
      req_error  <= take && ofs_bad;
      if (take_ok) begin
        state  <= SEQ_BURST;
        line_q <= req_addr[ADDR_W-1:LINE_LSB];
      end else if (adv && cnt_last) begin
        state <= SEQ_IDLE;
      end
    end
  end

  assign beat_valid = (state == SEQ_BURST);
  assign beat_idx   = cur_idx;
  assign beat_last  = beat_valid && cnt_last;
  assign beat_addr  = {line_q, cur_idx, {OFS_W{1'b0}}};

  // R8
  err_no_burst_chk: assert property (@(posedge clk) disable iff (rst)
    req_error |-> (!beat_valid && !req_accept));

  // R10
  accept_first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    req_accept |-> (beat_valid && !beat_last));

  // R4
  plain_write_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_accept && $past(req_write && !req_intervene)) |-> (beat_idx == '0));

  // R2
  critical_start_chk: assert property (@(posedge clk) disable iff (rst)
    (req_accept && $past(!req_write || req_intervene))
      |-> (beat_idx == $past(req_addr[LINE_LSB-1:OFS_W])));

  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_last && data_ack) |=> !beat_valid);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !(data_ack && beat_last)) |=> (!req_accept && !req_error));

endmodule

// File: tb/burst_beat_seq_bench.sv
`timescale 1ns/1ps
module burst_beat_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_intervene = 1'b0;
  logic        data_ack = 1'b0;
  logic        req_accept, req_error, beat_valid, beat_last;
  logic [1:0]  beat_idx;
  logic [31:0] beat_addr;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  burst_beat_seq u_burst_beat_seq (
    .clk, .rst, .req_valid, .req_addr, .req_write, .req_intervene,
    .data_ack, .req_accept, .req_error, .beat_valid, .beat_idx,
    .beat_addr, .beat_last
  );

  typedef struct packed {
    logic [31:0] a;
    logic        wr;
    logic        iv;
    logic [1:0]  st;
    logic [3:0]  stall;
    logic        intrude;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h0000_1000, 1'b0, 1'b0, 2'd0, 4'b0000, 1'b0},
    '{32'h0000_1008, 1'b0, 1'b0, 2'd1, 4'b0010, 1'b0},
    '{32'h0000_1010, 1'b0, 1'b0, 2'd2, 4'b0101, 1'b1},
    '{32'h0000_1018, 1'b0, 1'b0, 2'd3, 4'b1000, 1'b0},
    '{32'hFFFF_FFF8, 1'b1, 1'b1, 2'd3, 4'b0001, 1'b0},
    '{32'h0000_2010, 1'b1, 1'b1, 2'd2, 4'b0100, 1'b1},
    '{32'h0000_3018, 1'b1, 1'b0, 2'd0, 4'b0011, 1'b1},
    '{32'h8000_0008, 1'b1, 1'b0, 2'd0, 4'b0000, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_burst(input vec_t v);
    string tag;
    tag = (v.wr && !v.iv) ? "R4 order" : (v.iv ? "R3 order" : "R2 order");
    @(negedge clk);
    req_addr = v.a; req_write = v.wr; req_intervene = v.iv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_accept == 1'b1, "R10 accept pulse", 32'(req_accept), 32'd1);
    chk(req_error == 1'b0, "R8 no error on aligned", 32'(req_error), 32'd0);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] ei;
      ei = v.st + 2'(k);
      if (v.stall[k]) begin
        data_ack = 1'b0;
        if (v.intrude) begin
          req_valid = 1'b1; req_addr = v.a ^ 32'h0000_0019; req_write = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(beat_idx == ei, "R6 held during stall", 32'(beat_idx), 32'(ei));
        if (v.intrude) begin
          chk(!req_accept && !req_error, "R9 busy request ignored",
              {30'd0, req_accept, req_error}, 32'd0);
        end
      end
      chk(beat_valid == 1'b1, "R7 beat valid", 32'(beat_valid), 32'd1);
      chk(beat_idx == ei, tag, 32'(beat_idx), 32'(ei));
      chk(beat_addr == {v.a[31:5], ei, 3'b000}, "R5 beat address", beat_addr, {v.a[31:5], ei, 3'b000});
      chk(beat_last == (k == 3), "R7 last flag", 32'(beat_last), 32'(k == 3));
      data_ack = 1'b1;
      @(negedge clk);
      data_ack = 1'b0;
    end
    chk(beat_valid == 1'b0, "R7 idle after fourth beat", 32'(beat_valid), 32'd0);
    chk(req_accept == 1'b0, "R9 no stray accept", 32'(req_accept), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!beat_valid && !beat_last && !req_accept && !req_error, "R1 held in reset",
        {28'd0, beat_valid, beat_last, req_accept, req_error}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!beat_valid && !beat_last && !req_accept && !req_error, "R1 idle after reset",
        {28'd0, beat_valid, beat_last, req_accept, req_error}, 32'd0);

    foreach (VEC[i]) run_burst(VEC[i]);

    // R6: acknowledge while idle does nothing
    data_ack = 1'b1;
    @(negedge clk);
    @(negedge clk);
    data_ack = 1'b0;
    chk(beat_valid == 1'b0, "R6 ack while idle", 32'(beat_valid), 32'd0);

    // R8: misaligned request refused
    req_addr = 32'h0000_4004; req_write = 1'b0; req_intervene = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_error == 1'b1, "R8 error pulse", 32'(req_error), 32'd1);
    chk(!req_accept && !beat_valid, "R8 no burst on error",
        {30'd0, req_accept, beat_valid}, 32'd0);
    @(negedge clk);
    chk(req_error == 1'b0, "R8 error one cycle", 32'(req_error), 32'd0);
    chk(beat_valid == 1'b0, "R8 still idle", 32'(beat_valid), 32'd0);

    // R4: plain write from misaligned-free address with dw 2 still starts at zero
    run_burst('{32'h0000_5010, 1'b1, 1'b0, 2'd0, 4'b0000, 1'b0});

    // R1: reset in the middle of a burst
    req_addr = 32'h0000_6008; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(!beat_valid && !beat_last && !req_accept, "R1 reset mid-burst",
        {29'd0, beat_valid, beat_last, req_accept}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    run_burst('{32'h0000_7018, 1'b0, 1'b0, 2'd3, 4'b0000, 1'b0});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule